// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends data words on a single serial line, one bit for each edge of a shift clock that an external master drives. It never makes a clock of its own. The external clock is brought into the system clock domain through a short synchronizer, and an edge detector turns its transitions into one-cycle shift events. A polarity input selects which external edge moves the line to the next bit. The opposite edge, where the master samples, always finds the line stable.

A host writes words through a strobe. Two registers hold them. A one-word holding register sits in front of a shift register, so the host can queue a second word while the first is still going out. A buffer-empty flag reports when the holding register can take another word, and an interrupt request follows that flag when the interrupt enable is set. Frames are 8 bits long, or 9 bits when a host-supplied ninth bit is appended after the data.

Top module: `sync_slave_tx`

## Requirements
- R1: The line moves to the next bit only on the launch edge of `extClk`. With `clkPol`=0 the launch edge is the falling edge; with `clkPol`=1 it is the rising edge. On the opposite edge the line is stable.
- R2: Transmission is enabled only when `portEn`, `syncEn` and `txEn` are 1 and `masterSel`, `contRxEn` and `singleRxEn` are 0. In any other state both registers are emptied on the next clock and write strobes are ignored, so `shiftEmpty`=1, `bufEmpty`=1 and `txData`=0.
- R3: A write while the shift register is empty goes directly into the shift register. On the next cycle `shiftEmpty`=0, `bufEmpty` stays 1, and bit 0 of the word is on `txData`.
- R4: A write while a word is shifting goes into the holding register, and `bufEmpty` reads 0 on the next cycle.
- R5: The launch edge that follows the last bit of a frame moves the held word into the shift register and sets `bufEmpty`. The held word's bit 0 then drives the line.
- R6: `txIrq` is 1 exactly when `bufEmpty`=1 and `txIntEn`=1.
- R7: Data bits leave least significant bit first, one bit for each launch edge. An 8-bit frame ends on the 8th launch edge after loading.
- R8: When `nineBitMode`=1 at the write, the frame has 9 bits. Bit 8 is the `ninthBit` value captured at that write.
- R9: Clearing `txEn` aborts the frame in progress. On the next cycle both registers are empty, `bufEmpty`=1, `shiftEmpty`=1 and `txData`=0.
- R10: While `shiftEmpty`=1, `txData` is 0. `shiftEmpty` returns to 1 on the frame-ending launch edge when no word is held and none is written.
- R11: A write in the same cycle that a frame ends is not lost. If a word is held, the held word moves to the shift register and the new word takes its place, so `bufEmpty` stays 0. If no word is held, the new word loads directly into the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClk | input | 1 | Shift clock from the external master |
| clkPol | input | 1 | Launch-edge select: 0 falling, 1 rising |
| portEn | input | 1 | Serial port enable |
| syncEn | input | 1 | Synchronous mode enable |
| masterSel | input | 1 | Clock-source select; must be 0 for this mode |
| txEn | input | 1 | Transmit enable; 0 aborts and flushes |
| contRxEn | input | 1 | Continuous-receive enable; must be 0 |
| singleRxEn | input | 1 | Single-receive enable; must be 0 |
| nineBitMode | input | 1 | Frame width at write: 0 eight bits, 1 nine bits |
| ninthBit | input | 1 | Ninth bit value captured at write |
| wrStrobe | input | 1 | One-cycle write of `wrData` |
| wrData | input | DATA_W | Data word to send |
| txIntEn | input | 1 | Transmit interrupt enable |
| txData | output | 1 | Serial data line |
| bufEmpty | output | 1 | Holding register can accept a word |
| shiftEmpty | output | 1 | No word loaded or shifting |
| txIrq | output | 1 | Transmit interrupt request |

## Verification
A host write and the launch edge that ends a frame can be processed in the same system clock cycle. The bench provokes this by timing the write strobe against the synchronizer delay, so that it lands in the cycle the edge event is processed. It does this both with a held word and with an empty holding register. The result is judged at the ports: the bench reads the following frames bit by bit on the line, checking their order and content, and reads `bufEmpty` directly after the edge.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic loadWr;    // write word goes straight into the shift register
    logic loadHold;  // held word moves into the shift register
    logic holdWr;    // write word goes into the holding register
    logic shift;     // advance line to the next bit
    logic clear;     // empty both registers, line low
  } txStrobe_t;

endpackage

// File: rtl/sstx_clk_sync.sv
module sstx_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extClk,
  input  logic clkPol,
  output logic launchEdge
);

  // pipe[0..STAGES-1] synchronize, pipe[STAGES] is the previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], extClk};
  end

  logic riseSeen, fallSeen;
  assign riseSeen   =  pipe[STAGES-1] & ~pipe[STAGES];
  assign fallSeen   = ~pipe[STAGES-1] &  pipe[STAGES];
  assign launchEdge = clkPol ? riseSeen : fallSeen;

endmodule

// File: rtl/sstx_ctrl.sv
module sstx_ctrl
  import sstx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      active,
  input  logic      wrStrobe,
  input  logic      nineBitMode,
  input  logic      launchEdge,
  output txStrobe_t stb,
  output logic      holdFull,
  output logic      busy
);

  localparam int FRAME_W = DATA_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] bitsLeft;
  logic             holdNine;
  logic             frameEnd;

  assign frameEnd = busy & launchEdge & (bitsLeft == CNT_W'(1));

  always_comb begin
    stb = '0;
    if (!active) begin
      stb.clear = 1'b1;
    end else if (frameEnd) begin
      if (holdFull) begin
        stb.loadHold = 1'b1;
        stb.holdWr   = wrStrobe;
      end else if (wrStrobe) begin
        stb.loadWr = 1'b1;
      end else begin
        stb.clear = 1'b1;
      end
    end else begin
      stb.shift = busy & launchEdge;
      if (wrStrobe) begin
        if (busy) stb.holdWr = 1'b1;
        else      stb.loadWr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      holdFull <= 1'b0;
      holdNine <= 1'b0;
      bitsLeft <= '0;
    end else if (stb.clear) begin
      busy     <= 1'b0;
      holdFull <= 1'b0;
      bitsLeft <= '0;
    end else begin
      if (stb.shift) bitsLeft <= bitsLeft - CNT_W'(1);
      if (stb.loadWr) begin
        busy     <= 1'b1;
        bitsLeft <= nineBitMode ? LEN_LONG : LEN_SHORT;
      end
      if (stb.loadHold) begin
        bitsLeft <= holdNine ? LEN_LONG : LEN_SHORT;
        holdFull <= 1'b0;
      end
      if (stb.holdWr) begin
        holdFull <= 1'b1;
        holdNine <= nineBitMode;
      end
    end
  end

endmodule

// File: rtl/sstx_dpath.sv
module sstx_dpath
  import sstx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              nineBitMode,
  input  logic              ninthBit,
  output logic              txData
);

  localparam int FRAME_W = DATA_W + 1;

  logic [FRAME_W-1:0] shiftReg, holdReg, wrFrame;

  assign wrFrame = {nineBitMode & ninthBit, wrData};
  assign txData  = shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      shiftReg <= '0;
      holdReg  <= '0;
    end else begin
      if (stb.shift)    shiftReg <= shiftReg >> 1;
      if (stb.loadWr)   shiftReg <= wrFrame;
      if (stb.loadHold) shiftReg <= holdReg;
      if (stb.holdWr)   holdReg  <= wrFrame;
    end
  end

endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sstx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClk,
  input  logic              clkPol,
  input  logic              portEn,
  input  logic              syncEn,
  input  logic              masterSel,
  input  logic              txEn,
  input  logic              contRxEn,
  input  logic              singleRxEn,
  input  logic              nineBitMode,
  input  logic              ninthBit,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txIntEn,
  output logic              txData,
  output logic              bufEmpty,
  output logic              shiftEmpty,
  output logic              txIrq
);

  txStrobe_t stb;
  logic      launchEdge, active, holdFull, busy;

  assign active = portEn & syncEn & txEn & ~masterSel & ~contRxEn & ~singleRxEn;

  sstx_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .extClk(extClk), .clkPol(clkPol),
    .launchEdge(launchEdge)
  );

  sstx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .active(active), .wrStrobe(wrStrobe),
    .nineBitMode(nineBitMode), .launchEdge(launchEdge),
    .stb(stb), .holdFull(holdFull), .busy(busy)
  );

  sstx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .nineBitMode(nineBitMode), .ninthBit(ninthBit), .txData(txData)
  );

  assign bufEmpty   = ~holdFull;
  assign shiftEmpty = ~busy;
  assign txIrq      = bufEmpty & txIntEn;

endmodule

// File: rtl/sstx_checker.sv
module sstx_checker (
  input logic clk,
  input logic rstN,
  input logic portEn,
  input logic syncEn,
  input logic masterSel,
  input logic txEn,
  input logic contRxEn,
  input logic singleRxEn,
  input logic wrStrobe,
  input logic txIntEn,
  input logic txData,
  input logic bufEmpty,
  input logic shiftEmpty,
  input logic txIrq
);

  // R4
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufEmpty) |-> $past(wrStrobe));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (bufEmpty && txIntEn));

  // R9
  abort_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> (bufEmpty && shiftEmpty && !txData));

  // R2
  rx_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (contRxEn || singleRxEn || masterSel) |=> (shiftEmpty && bufEmpty));

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> !txData);

  // R3
  direct_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && shiftEmpty && portEn && syncEn && txEn && !masterSel
     && !contRxEn && !singleRxEn) |=> (!shiftEmpty && bufEmpty));

endmodule

bind sync_slave_tx sstx_checker u_chk (
  .clk(clk), .rstN(rstN), .portEn(portEn), .syncEn(syncEn),
  .masterSel(masterSel), .txEn(txEn), .contRxEn(contRxEn),
  .singleRxEn(singleRxEn), .wrStrobe(wrStrobe), .txIntEn(txIntEn),
  .txData(txData), .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty),
  .txIrq(txIrq)
);

// File: tb/sync_slave_tx_tb.sv
`timescale 1ns/1ps
module sync_slave_tx_tb;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rstN, extClk, clkPol, portEn, syncEn, masterSel, txEn;
  logic contRxEn, singleRxEn, nineBitMode, ninthBit, wrStrobe, txIntEn;
  logic [7:0] wrData;
  logic txData, bufEmpty, shiftEmpty, txIrq;

  sync_slave_tx u_dut (
    .clk(clk), .rstN(rstN), .extClk(extClk), .clkPol(clkPol),
    .portEn(portEn), .syncEn(syncEn), .masterSel(masterSel), .txEn(txEn),
    .contRxEn(contRxEn), .singleRxEn(singleRxEn), .nineBitMode(nineBitMode),
    .ninthBit(ninthBit), .wrStrobe(wrStrobe), .wrData(wrData),
    .txIntEn(txIntEn), .txData(txData), .bufEmpty(bufEmpty),
    .shiftEmpty(shiftEmpty), .txIrq(txIrq)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;
  logic [8:0] fq[$];
  int         lq[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] mkFrame(input logic [7:0] d, input logic nine, input logic b9);
    return {nine & b9, d};
  endfunction

  function automatic logic expBuf();
    return fq.size() < 2;
  endfunction

  // write that the model expects to be accepted
  task automatic doWrite(input logic [7:0] d, input logic nine, input logic b9);
    @(negedge clk);
    wrData = d; nineBitMode = nine; ninthBit = b9; wrStrobe = 1;
    @(negedge clk);
    wrStrobe = 0;
    fq.push_back(mkFrame(d, nine, b9));
    lq.push_back(nine ? 9 : 8);
  endtask

  // write that must be ignored
  task automatic rawWrite(input logic [7:0] d);
    @(negedge clk);
    wrData = d; nineBitMode = 0; wrStrobe = 1;
    @(negedge clk);
    wrStrobe = 0;
  endtask

  // one launch edge then the opposite edge; optional write timed to the edge cycle
  task automatic pulse(input logic withWr, input logic [7:0] d, input logic nine, input logic b9);
    @(negedge clk); extClk = clkPol;
    @(negedge clk);
    @(negedge clk);
    if (withWr) begin
      wrData = d; nineBitMode = nine; ninthBit = b9; wrStrobe = 1;
    end
    @(negedge clk);
    wrStrobe = 0;
    if (withWr) begin
      fq.push_back(mkFrame(d, nine, b9));
      lq.push_back(nine ? 9 : 8);
    end
    repeat (5) @(negedge clk);
    extClk = ~clkPol;
    repeat (8) @(negedge clk);
  endtask

  task automatic drain(input logic collide, input logic [7:0] d, input logic nine, input logic b9);
    logic [8:0] frame;
    int len;
    frame = fq[0];
    len   = lq[0];
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 8) chk("R8 ninth bit", txData, frame[k]);
      else        chk("R1/R7 data bit", txData, frame[k]);
      pulse(collide && (k == len - 1), d, nine, b9);
    end
    void'(fq.pop_front());
    void'(lq.pop_front());
    @(negedge clk);
    if (fq.size() == 0) begin
      chk("R10 shiftEmpty after frame", shiftEmpty, 1);
      chk("R10 line low when idle", txData, 0);
    end else begin
      chk("R5 shiftEmpty with next word", shiftEmpty, 0);
      chk("R5/R11 bufEmpty after edge", bufEmpty, expBuf());
    end
    chk("R6 irq after frame", txIrq, expBuf() & txIntEn);
  endtask

  task automatic setPol(input logic p);
    @(negedge clk);
    clkPol = p;
    extClk = ~p;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 0; extClk = 1; clkPol = 0; portEn = 1; syncEn = 1; masterSel = 0;
    txEn = 1; contRxEn = 0; singleRxEn = 0; nineBitMode = 0; ninthBit = 0;
    wrStrobe = 0; wrData = 0; txIntEn = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R10 reset shiftEmpty", shiftEmpty, 1);
    chk("R4 reset bufEmpty", bufEmpty, 1);
    chk("R10 reset line", txData, 0);
    chk("R6 reset irq disabled", txIrq, 0);
    txIntEn = 1;
    @(negedge clk);
    chk("R6 irq enabled while empty", txIrq, 1);

    // directed: two words, 8-bit then 9-bit
    doWrite(8'hA5, 0, 0);
    chk("R3 direct load shiftEmpty", shiftEmpty, 0);
    chk("R3 direct load bufEmpty", bufEmpty, 1);
    chk("R3 bit0 on line", txData, 1);
    doWrite(8'h3C, 1, 1);
    chk("R4 held word bufEmpty", bufEmpty, 0);
    chk("R6 irq off while held", txIrq, 0);
    drain(0, 0, 0, 0);
    drain(0, 0, 0, 0);

    // collision with empty holding register, rising-edge polarity
    setPol(1);
    doWrite(8'h81, 0, 0);
    drain(1, 8'h5E, 1, 0);
    drain(0, 0, 0, 0);

    // collision with a held word
    doWrite(8'h0F, 0, 0);
    doWrite(8'hF0, 1, 1);
    drain(1, 8'h66, 0, 0);
    chk("R11 bufEmpty stays low", bufEmpty, 0);
    drain(0, 0, 0, 0);
    drain(0, 0, 0, 0);

    // abort by clearing the transmit enable mid-frame
    doWrite(8'hC3, 0, 0);
    doWrite(8'h99, 0, 0);
    pulse(0, 0, 0, 0);
    pulse(0, 0, 0, 0);
    @(negedge clk); txEn = 0;
    @(negedge clk);
    chk("R9 abort bufEmpty", bufEmpty, 1);
    chk("R9 abort shiftEmpty", shiftEmpty, 1);
    chk("R9 abort line low", txData, 0);
    fq.delete(); lq.delete();
    rawWrite(8'hFF);
    chk("R2 write ignored without txEn", shiftEmpty, 1);
    txEn = 1;

    // blocked by receive enables and master select
    contRxEn = 1;
    rawWrite(8'hFF);
    chk("R2 write ignored with contRxEn", shiftEmpty, 1);
    chk("R2 line stays low contRxEn", txData, 0);
    contRxEn = 0; singleRxEn = 1;
    rawWrite(8'hFF);
    chk("R2 write ignored with singleRxEn", shiftEmpty, 1);
    singleRxEn = 0; masterSel = 1;
    rawWrite(8'hFF);
    chk("R2 write ignored with masterSel", shiftEmpty, 1);
    chk("R2 bufEmpty with masterSel", bufEmpty, 1);
    masterSel = 0;

    // constrained random
    for (int it = 0; it < 30; it++) begin
      int nw;
      int collides;
      if ($urandom % 3 == 0) setPol(logic'($urandom % 2));
      txIntEn = logic'($urandom % 2);
      nw = 1 + ($urandom % 2);
      for (int w = 0; w < nw; w++) begin
        doWrite(8'($urandom), logic'($urandom % 2), logic'($urandom % 2));
        chk("R3/R4 bufEmpty after write", bufEmpty, expBuf());
        chk("R3 shiftEmpty after write", shiftEmpty, 0);
      end
      collides = 0;
      while (fq.size() > 0) begin
        logic doCol;
        doCol = (collides < 2) && ($urandom % 3 == 0);
        if (doCol) collides++;
        drain(doCol, 8'($urandom), logic'($urandom % 2), logic'($urandom % 2));
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule